// File: doc/BRIEF.md
# Stretched Multiplexed-Bus Data Cycle Sequencer

This block runs a single external data-memory transfer, read or write, over a bus that carries the low address byte and the data byte on the same wires. A request pulse starts the transfer and selects its direction. The request also supplies the address byte, the write byte and a 3-bit stretch code. The sequencer then drives the address-latch strobe, the shared byte with its output enable and the active-low read and write strobes. At the end it raises a completion pulse, and on a read it keeps the byte it captured.

The block is clocked by a phase clock that runs at twice the system clock, so one phase is half a system clock. The stretch code falls into one of three bands: zero, one to three, and four to seven. The band scales the latch-strobe width and the address setup and hold around the latch strobe's falling edge. The code itself scales the read/write strobe width. The stretch code is captured together with the request, so a change during a transfer does not affect that transfer.

Top module: `xbus_stretch_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a request arrives, ale=0, bus_oe=0, rd_n=1, wr_n=1, done=0 and rdata=0.
- R2: ale rises in the phase after an idle phase in which start is sampled high. It stays high for 3 phases when stretch=0, for 4 phases when stretch is 1 to 3, and for 12 phases when stretch is 4 to 7.
- R3: bus_out carries the address with bus_oe=1 during the last S phases of ale high and during the S phases that follow ale's fall. S is 1 for stretch=0, 2 for stretch 1 to 3, and 10 for stretch 4 to 7. In the earlier ale-high phases bus_oe=0.
- R4: The strobe (rd_n on a read with wr_sel=0, wr_n on a write with wr_sel=1) goes low right after address hold. It stays low for 4 phases when stretch=0 and for 8×stretch phases otherwise. The other strobe stays high, and the two are never low together.
- R5: On a write, bus_out carries the write byte with bus_oe=1 from the end of address hold until one phase after wr_n rises.
- R6: On a read, bus_oe=0 from the end of address hold to the end of the transfer. rdata takes the value bus_in had in the last phase of rd_n low and holds it until the next read.
- R7: done is high for exactly two phases (one system clock), starting in the phase right after the strobe rises. The sequencer is idle in the phase after that.
- R8: start is ignored while a transfer is in progress, including in the last done phase. Changes to stretch, wr_sel, addr and wdata after the request is accepted do not alter the transfer.
- R9: With start held high, a new transfer begins after exactly one idle phase following done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock, twice the system clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer request, sampled in idle |
| wr_sel | input | 1 | 1 = write, 0 = read |
| stretch | input | 3 | Stretch code 0 to 7 |
| addr | input | 8 | Low address byte |
| wdata | input | 8 | Write byte |
| bus_in | input | 8 | Byte read from the shared bus |
| bus_out | output | 8 | Byte driven onto the shared bus |
| bus_oe | output | 1 | Output enable for bus_out |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| done | output | 1 | Completion pulse |
| rdata | output | 8 | Captured read byte |

## Verification
The sequencer's state is a phase kind and a down-counter. A wrong counter load or a wrong band decode shows up within one phase of the affected segment boundary, as a strobe edge or an enable edge one or more phases away from its expected position. A wrong capture point gives a wrong rdata in the phase right after rd_n rises, because bus_in takes a new value every phase. A transfer that latched a stale stretch code or direction has its strobe in the wrong place or of the wrong length within that same transfer. A phase-exact model compared on every phase catches each of these at the first phase where the behaviour departs from the requirements.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_HOLD = 3'd2,
    ST_STRB = 3'd3,
    ST_DONE = 3'd4
  } seq_state_t;
endpackage

// File: rtl/xbus_stretch_decode.sv
module xbus_stretch_decode #(
  parameter int SW = 3,
  parameter int CW = 6
) (
  input  logic [SW-1:0] code,
  output logic [CW-1:0] ale_len,
  output logic [CW-1:0] su_len,
  output logic [CW-1:0] hold_len,
  output logic [CW-1:0] strb_len
);
  // Lengths are in phases (half system clocks).
  always_comb begin
    if (code == '0) begin
      ale_len  = CW'(3);
      su_len   = CW'(1);
      hold_len = CW'(1);
      strb_len = CW'(4);
    end else if (code < SW'(4)) begin
      ale_len  = CW'(4);
      su_len   = CW'(2);
      hold_len = CW'(2);
      strb_len = CW'(code) << 3;
    end else begin
      ale_len  = CW'(12);
      su_len   = CW'(10);
      hold_len = CW'(10);
      strb_len = CW'(code) << 3;
    end
  end
endmodule

// File: rtl/xbus_seq_fsm.sv
module xbus_seq_fsm
  import xbus_seq_pkg::*;
#(
  parameter int SW = 3,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr_sel,
  input  logic [SW-1:0] stretch_in,
  output seq_state_t    state,
  output logic [CW-1:0] cnt,
  output logic          wr_q,
  output logic [CW-1:0] su_len,
  output logic          accept
);
  seq_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] str_q, str_d;
  logic          wr_d, wr_r;
  logic [SW-1:0] code_sel;
  logic [CW-1:0] ale_len, hold_len, strb_len;

  assign code_sel = (st_q == ST_IDLE) ? stretch_in : str_q;

  xbus_stretch_decode #(.SW(SW), .CW(CW)) u_dec (
    .code     (code_sel),
    .ale_len  (ale_len),
    .su_len   (su_len),
    .hold_len (hold_len),
    .strb_len (strb_len)
  );

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    str_d  = str_q;
    wr_d   = wr_r;
    accept = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        accept = 1'b1;
        st_d   = ST_ADDR;
        cnt_d  = ale_len - CW'(1);
        str_d  = stretch_in;
        wr_d   = wr_sel;
      end
      ST_ADDR: if (cnt_q == '0) begin
        st_d  = ST_HOLD;
        cnt_d = hold_len - CW'(1);
      end else cnt_d = cnt_q - CW'(1);
      ST_HOLD: if (cnt_q == '0) begin
        st_d  = ST_STRB;
        cnt_d = strb_len - CW'(1);
      end else cnt_d = cnt_q - CW'(1);
      ST_STRB: if (cnt_q == '0) begin
        st_d  = ST_DONE;
        cnt_d = CW'(1);
      end else cnt_d = cnt_q - CW'(1);
      ST_DONE: if (cnt_q == '0) st_d = ST_IDLE;
               else cnt_d = cnt_q - CW'(1);
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      str_q <= '0;
      wr_r  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      str_q <= str_d;
      wr_r  <= wr_d;
    end
  end

  assign state = st_q;
  assign cnt   = cnt_q;
  assign wr_q  = wr_r;

  // R8
  stretch_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> ($stable(str_q) && $stable(wr_r)));
  // R8
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |=> (st_q != ST_ADDR));
endmodule

// File: rtl/xbus_bus_drive.sv
module xbus_bus_drive
  import xbus_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  seq_state_t    state,
  input  logic [CW-1:0] cnt,
  input  logic          wr_q,
  input  logic [CW-1:0] su_len,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          done,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] addr_q, addr_d, wd_q, wd_d, rd_q, rd_d;
  logic          cap_en, addr_ph;

  assign cap_en = (state == ST_STRB) && (cnt == '0) && !wr_q;

  always_comb begin
    addr_d = accept ? addr  : addr_q;
    wd_d   = accept ? wdata : wd_q;
    rd_d   = cap_en ? bus_in : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      addr_q <= addr_d;
      wd_q   <= wd_d;
      rd_q   <= rd_d;
    end
  end

  assign addr_ph = (state == ST_ADDR) || (state == ST_HOLD);
  assign ale     = (state == ST_ADDR);
  assign bus_oe  = ((state == ST_ADDR) && (cnt < su_len)) || (state == ST_HOLD) ||
                   (wr_q && ((state == ST_STRB) || ((state == ST_DONE) && (cnt == CW'(1)))));
  assign bus_out = addr_ph ? addr_q : wd_q;
  assign rd_n    = !((state == ST_STRB) && !wr_q);
  assign wr_n    = !((state == ST_STRB) && wr_q);
  assign done    = (state == ST_DONE);
  assign rdata   = rd_q;

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) (rd_n || wr_n));
  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !bus_oe);
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (bus_oe && bus_out == $past(bus_out)));
  // R7
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!rd_n || !wr_n));
endmodule

// File: rtl/xbus_stretch_seq.sv
module xbus_stretch_seq
  import xbus_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr_sel,
  input  logic [SW-1:0] stretch,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          done,
  output logic [DW-1:0] rdata
);
  localparam int MAX_STRB = 8 * ((1 << SW) - 1);
  localparam int CW       = $clog2(MAX_STRB + 1);

  logic [1:0]    rs_q;
  logic          rst_i_n;
  seq_state_t    state;
  logic [CW-1:0] cnt, su_len;
  logic          wr_q, accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  xbus_seq_fsm #(.SW(SW), .CW(CW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .start      (start),
    .wr_sel     (wr_sel),
    .stretch_in (stretch),
    .state      (state),
    .cnt        (cnt),
    .wr_q       (wr_q),
    .su_len     (su_len),
    .accept     (accept)
  );

  xbus_bus_drive #(.DW(DW), .CW(CW)) u_drv (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .accept  (accept),
    .state   (state),
    .cnt     (cnt),
    .wr_q    (wr_q),
    .su_len  (su_len),
    .addr    (addr),
    .wdata   (wdata),
    .bus_in  (bus_in),
    .bus_out (bus_out),
    .bus_oe  (bus_oe),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .done    (done),
    .rdata   (rdata)
  );
endmodule

// File: tb/tb_xbus_stretch_seq.sv
module tb_xbus_stretch_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, wr_sel;
  logic [2:0] stretch;
  logic [7:0] addr, wdata, bus_in, bus_out, rdata;
  logic bus_oe, ale, rd_n, wr_n, done;

  xbus_stretch_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_sel(wr_sel), .stretch(stretch),
    .addr(addr), .wdata(wdata), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .done(done), .rdata(rdata)
  );

  typedef struct packed {
    logic ale, oe; logic [7:0] val; logic rd_n, wr_n, done, cap;
  } ph_t;

  ph_t q[$];
  bit idle_now = 1'b1, cap_now = 1'b0;
  logic [7:0] exp_rdata = 8'h00;
  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic ph_t mk(bit a, bit oe, logic [7:0] v, bit r, bit w, bit d, bit c);
    ph_t p;
    p.ale = a; p.oe = oe; p.val = v; p.rd_n = r; p.wr_n = w; p.done = d; p.cap = c;
    return p;
  endfunction

  // Expected phase sequence, written from the requirements.
  function automatic void fill(int st, bit wr, logic [7:0] a, logic [7:0] d);
    int al, su, sb;
    if (st == 0)     begin al = 3;  su = 1;  sb = 4;      end
    else if (st < 4) begin al = 4;  su = 2;  sb = 8 * st; end
    else             begin al = 12; su = 10; sb = 8 * st; end
    for (int i = 0; i < al; i++) q.push_back(mk(1, i >= al - su, a, 1, 1, 0, 0));
    for (int i = 0; i < su; i++) q.push_back(mk(0, 1, a, 1, 1, 0, 0));
    for (int i = 0; i < sb; i++) q.push_back(mk(0, wr, d, wr, !wr, 0, !wr && i == sb - 1));
    q.push_back(mk(0, wr, d, 1, 1, 1, 0));
    q.push_back(mk(0, 0, d, 1, 1, 1, 0));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      exp_rdata = 8'h00;
    end else begin
      if (cap_now) exp_rdata = bus_in;          // R6 capture point
      if (idle_now && start) fill(stretch, wr_sel, addr, wdata);  // R8 R9
    end
  end

  always @(negedge clk) begin
    ph_t e;
    if (q.size() == 0) begin
      idle_now = 1'b1; cap_now = 1'b0; e = mk(0, 0, 0, 1, 1, 0, 0);
    end else begin
      idle_now = 1'b0; e = q.pop_front(); cap_now = e.cap;
    end
    chk(ale === e.ale, "R2", "ale", int'(ale), int'(e.ale));
    chk(bus_oe === e.oe, "R3,R5,R6", "bus_oe", int'(bus_oe), int'(e.oe));
    if (e.oe) chk(bus_out === e.val, "R3,R5", "bus_out", int'(bus_out), int'(e.val));
    chk(rd_n === e.rd_n, "R4", "rd_n", int'(rd_n), int'(e.rd_n));
    chk(wr_n === e.wr_n, "R4", "wr_n", int'(wr_n), int'(e.wr_n));
    chk(done === e.done, "R7", "done", int'(done), int'(e.done));
    chk(rdata === exp_rdata, "R6", "rdata", int'(rdata), int'(exp_rdata));
  end

  always @(negedge clk) bus_in <= bus_in + 8'd37;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "timeout", 1, 0);
    finish_run();
  end

  task automatic wait_idle();
    do @(negedge clk); while (!idle_now);
  endtask

  // R8: inputs are scrambled right after acceptance.
  task automatic run(input int st, input bit wr, input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    start = 1; wr_sel = wr; stretch = 3'(st); addr = a; wdata = d;
    @(posedge clk); #2;
    start = 0; wr_sel = ~wr; stretch = ~stretch; addr = ~a; wdata = ~d;
    wait_idle();
  endtask

  initial begin
    rst_n = 0; start = 0; wr_sel = 0; stretch = 0; addr = 0; wdata = 0; bus_in = 8'h5A;
    repeat (3) @(negedge clk);
    // R1: explicit reset-state checks
    chk(ale === 1'b0 && bus_oe === 1'b0, "R1", "ale/oe", int'({ale, bus_oe}), 0);
    chk(rd_n === 1'b1 && wr_n === 1'b1 && done === 1'b0, "R1", "rd_n/wr_n/done",
        int'({rd_n, wr_n, done}), 6);
    chk(rdata === 8'h00, "R1", "rdata", int'(rdata), 0);
    @(posedge clk); #2 rst_n = 1;
    repeat (4) @(posedge clk);
    // R2 R3 R4 R5 R6 R7: every stretch code, both directions
    for (int s = 0; s < 8; s++) begin
      run(s, 1'b1, 8'(8'h11 * s + 3), 8'(8'hC3 ^ (s * 29)));
      run(s, 1'b0, 8'(8'hF0 - s * 7), 8'h00);
    end
    // R9 and R8: start held high, stretch and direction changing every phase
    @(posedge clk); #2;
    start = 1; wr_sel = 1; stretch = 3'd2; addr = 8'hA5; wdata = 8'h3C;
    for (int k = 0; k < 120; k++) begin
      @(posedge clk); #2;
      stretch = 3'(k % 5); wr_sel = k[1]; addr = 8'(k * 3); wdata = 8'(k * 11);
    end
    start = 0;
    wait_idle();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule